// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the integer registers of a 32-bit RISC core that runs in seven operating modes. Software sees sixteen logical registers, selected by a 4-bit index. The current mode chooses which physical copy of the upper general registers, the stack pointer (index 13) and the link register (index 14) each index reaches. Storage is 30 general registers, a program counter, and five saved status registers, one for each privileged exception mode.

Two read ports return data combinationally. One write port updates a register on the rising clock edge. Logical index 15 reads the program counter. The program counter changes only through its own load input. The current mode also selects the saved status register that is read and written through a separate data path. A force-user input maps indices 8 to 14 onto the user copies, which lets a privileged transfer reach user registers. A mode code that is not recognised is banked as user mode and raises a flag.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every general register, the program counter and every saved status register read as zero, and illegal_mode is low in user mode.
- R2: Indices 0 to 7 reach the same physical registers in every mode, including an unrecognised mode.
- R3: In fast interrupt mode (mode code 5'b10001), indices 8 to 14 reach seven registers that are private to that mode.
- R4: In interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes, indices 13 and 14 reach a pair private to each mode, and indices 8 to 12 reach the user copies.
- R5: System mode (5'b11111) reaches exactly the registers of user mode (5'b10000).
- R6: Each of the five modes fast interrupt, interrupt, supervisor, abort and undefined has its own saved status register. In user, system or an unrecognised mode, a saved-status read returns zero and a saved-status write changes nothing.
- R7: Any mode code outside the seven listed codes sets illegal_mode high and uses user banking. illegal_mode is low for the seven listed codes.
- R8: While force_user is high, indices 8 to 14 reach the user copies whatever the mode. force_user has no effect on indices 0 to 7.
- R9: A read of a register in the same cycle as a write to it returns the old value. The new value is visible from the cycle after the write edge.
- R10: Index 15 on either read port returns the program counter. The program counter loads pc_next on a clock edge with pc_we high. A general write to index 15 changes no register.
- R11: The two read ports address registers independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Current operating mode code |
| force_user | input | 1 | Map indices 8 to 14 to the user copies |
| rd_a_idx | input | 4 | Read port A logical index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B logical index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Write logical index |
| wr_data | input | 32 | Write data |
| pc_we | input | 1 | Program counter load enable |
| pc_next | input | 32 | Program counter load value |
| pc_o | output | 32 | Program counter value |
| spsr_we | input | 1 | Saved status write enable |
| spsr_wdata | input | 32 | Saved status write data |
| spsr_rdata | output | 32 | Saved status of the current mode |
| illegal_mode | output | 1 | Mode code not recognised |

## Verification
The assertions check invariants on every cycle:
- Indices below 8 keep their identity mapping.
- An unrecognised mode falls back to user banking.
- At most one physical register is written per edge.
- A completed write lands in the physical slot it was mapped to.
- The program counter holds without pc_we.
- Saved status reads zero and stays frozen when the mode has no saved status register.

Only the bench scenarios show that the banks are separated correctly. The bench writes every index in every mode, then reads all of them back from every mode on both ports. It checks force_user aliasing and the old value on a same-cycle read of a register being written. It also checks that a write to index 15 leaves the program counter untouched.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int NUM_PHYS = 30;
  localparam int PHYS_W   = $clog2(NUM_PHYS);
  localparam int NUM_SAVE = 5;
  localparam int SAVE_W   = $clog2(NUM_SAVE);

  localparam int FIQ_BASE = 15;
  localparam int EXC_BASE = 22;

  typedef enum logic [4:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } cpu_mode_e;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  function automatic logic mode_known(logic [4:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  function automatic bank_e mode_bank(logic [4:0] m);
    case (m)
      MODE_FIQ: return BK_FIQ;
      MODE_IRQ: return BK_IRQ;
      MODE_SVC: return BK_SVC;
      MODE_ABT: return BK_ABT;
      MODE_UND: return BK_UND;
      default:  return BK_USR;
    endcase
  endfunction

  // Physical slot of logical index 0..14 inside a bank.
  function automatic logic [PHYS_W-1:0] phys_index(bank_e b, logic [3:0] idx);
    int slot;
    slot = int'(idx);
    if (idx >= 4'd8) begin
      if (b == BK_FIQ)
        slot = FIQ_BASE + int'(idx) - 8;
      else if (b != BK_USR && idx >= 4'd13)
        slot = EXC_BASE + 2 * (int'(b) - int'(BK_IRQ)) + int'(idx) - 13;
    end
    return PHYS_W'(slot);
  endfunction

endpackage

// File: rtl/regbank_mode_dec.sv
module regbank_mode_dec
  import regbank_pkg::*;
(
  input  logic [4:0]        mode_i,
  output bank_e             bank_o,
  output logic              illegal_o,
  output logic              save_valid_o,
  output logic [SAVE_W-1:0] save_sel_o
);

  always_comb begin
    illegal_o    = !mode_known(mode_i);
    bank_o       = mode_bank(mode_i);
    save_valid_o = (bank_o != BK_USR);
    save_sel_o   = save_valid_o ? SAVE_W'(int'(bank_o) - 1) : '0;
  end

  always_comb begin
    if (illegal_o) begin
      assert_illegal_user_R7: assert (bank_o == BK_USR && !save_valid_o);
    end
  end

endmodule

// File: rtl/regbank_map.sv
module regbank_map
  import regbank_pkg::*;
(
  input  bank_e             bank_i,
  input  logic              force_user_i,
  input  logic [3:0]        idx_i,
  output logic [PHYS_W-1:0] phys_o,
  output logic              is_pc_o
);

  bank_e eff_bank;

  always_comb begin
    eff_bank = force_user_i ? BK_USR : bank_i;
    is_pc_o  = (idx_i == 4'd15);
    phys_o   = is_pc_o ? '0 : phys_index(eff_bank, idx_i);
  end

  always_comb begin
    if (idx_i < 4'd8) begin
      assert_shared_low_R2: assert (phys_o == PHYS_W'(idx_i));
    end
    if (!is_pc_o) begin
      assert_in_range_R3: assert (int'(phys_o) < NUM_PHYS);
    end
    if (force_user_i && !is_pc_o) begin
      assert_force_user_R8: assert (int'(phys_o) < FIQ_BASE);
    end
  end

endmodule

// File: rtl/regbank_save.sv
module regbank_save
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [SAVE_W-1:0] sel_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0]          slot_q [NUM_SAVE];
  logic [NUM_SAVE*DATA_W-1:0] slot_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SAVE; i++) slot_q[i] <= '0;
    end else if (we_i && valid_i) begin
      slot_q[sel_i] <= wdata_i;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_SAVE; g++) begin : g_flat
      assign slot_flat[g*DATA_W +: DATA_W] = slot_q[g];
    end
  endgenerate

  assign rdata_o = valid_i ? slot_q[sel_i] : '0;

  assert_save_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(slot_flat));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode_i,
  input  logic              force_user,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pc_we,
  input  logic [DATA_W-1:0] pc_next,
  output logic [DATA_W-1:0] pc_o,
  input  logic              spsr_we,
  input  logic [DATA_W-1:0] spsr_wdata,
  output logic [DATA_W-1:0] spsr_rdata,
  output logic              illegal_mode
);

  localparam int NPORT = 3;  // 0: read A, 1: read B, 2: write

  bank_e             cur_bank;
  logic              save_valid;
  logic [SAVE_W-1:0] save_sel;

  regbank_mode_dec u_dec (
    .mode_i       (mode_i),
    .bank_o       (cur_bank),
    .illegal_o    (illegal_mode),
    .save_valid_o (save_valid),
    .save_sel_o   (save_sel)
  );

  logic [3:0]        port_idx   [NPORT];
  logic [PHYS_W-1:0] port_phys  [NPORT];
  logic              port_is_pc [NPORT];

  assign port_idx[0] = rd_a_idx;
  assign port_idx[1] = rd_b_idx;
  assign port_idx[2] = wr_idx;

  genvar p;
  generate
    for (p = 0; p < NPORT; p++) begin : g_map
      regbank_map u_map (
        .bank_i       (cur_bank),
        .force_user_i (force_user),
        .idx_i        (port_idx[p]),
        .phys_o       (port_phys[p]),
        .is_pc_o      (port_is_pc[p])
      );
    end
  endgenerate

  logic [DATA_W-1:0]   gpr_q [NUM_PHYS];
  logic [NUM_PHYS-1:0] gpr_we;
  logic [DATA_W-1:0]   pc_q;

  always_comb begin
    for (int i = 0; i < NUM_PHYS; i++)
      gpr_we[i] = wr_en && !port_is_pc[2] && (int'(port_phys[2]) == i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++) gpr_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_PHYS; i++)
        if (gpr_we[i]) gpr_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_we) pc_q <= pc_next;
  end

  assign pc_o      = pc_q;
  assign rd_a_data = port_is_pc[0] ? pc_q : gpr_q[port_phys[0]];
  assign rd_b_data = port_is_pc[1] ? pc_q : gpr_q[port_phys[1]];

  regbank_save #(.DATA_W(DATA_W)) u_save (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (save_valid),
    .sel_i   (save_sel),
    .we_i    (spsr_we),
    .wdata_i (spsr_wdata),
    .rdata_o (spsr_rdata)
  );

  // Record of the last completed write, used by the landing check.
  logic              last_vld;
  logic [PHYS_W-1:0] last_phys;
  logic [DATA_W-1:0] last_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_vld  <= 1'b0;
      last_phys <= '0;
      last_data <= '0;
    end else begin
      last_vld  <= wr_en && !port_is_pc[2];
      last_phys <= port_phys[2];
      last_data <= wr_data;
    end
  end

  assert_single_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gpr_we));

  assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    last_vld |-> gpr_q[last_phys] == last_data);

  assert_pc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> $stable(pc_q));

  assert_pc_index_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd15) |-> gpr_we == '0);

endmodule

// File: tb/tb_banked_regfile.sv
`timescale 1ns/1ps
module tb_banked_regfile;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [4:0]   mode_i = 5'b10000;
  logic         force_user = 1'b0;
  logic [3:0]   rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [W-1:0] rd_a_data, rd_b_data, wr_data = '0, pc_next = '0, pc_o;
  logic [W-1:0] spsr_wdata = '0, spsr_rdata;
  logic         wr_en = 1'b0, pc_we = 1'b0, spsr_we = 1'b0, illegal_mode;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;  // 125 MHz

  banked_regfile #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .force_user(force_user),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_we(pc_we), .pc_next(pc_next), .pc_o(pc_o),
    .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .spsr_rdata(spsr_rdata),
    .illegal_mode(illegal_mode)
  );

  // Bench model: one row of 15 values per owner (0 user, 1..5 exception owners).
  logic [W-1:0] model [6][15];
  logic [W-1:0] save_model [6];
  logic [W-1:0] pc_model;

  logic [4:0] modes [8];
  initial begin
    modes[0] = 5'b10000; modes[1] = 5'b10001; modes[2] = 5'b10010;
    modes[3] = 5'b10011; modes[4] = 5'b10111; modes[5] = 5'b11011;
    modes[6] = 5'b11111; modes[7] = 5'b00110;
  end

  function automatic int owner_of(logic [4:0] m);
    if (m == 5'b10001) return 1;
    if (m == 5'b10010) return 2;
    if (m == 5'b10011) return 3;
    if (m == 5'b10111) return 4;
    if (m == 5'b11011) return 5;
    return 0;
  endfunction

  function automatic int row_for(logic [4:0] m, logic fu, int idx);
    int o;
    o = owner_of(m);
    if (idx < 8 || fu || o == 0) return 0;
    if (o == 1) return 1;
    return (idx >= 13) ? o : 0;
  endfunction

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] m, logic fu, int idx, logic [W-1:0] d);
    @(negedge clk);
    mode_i = m; force_user = fu; wr_idx = 4'(idx); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx != 15) model[row_for(m, fu, idx)][idx] = d;
  endtask

  task automatic sweep_reads(string req);
    for (int mi = 0; mi < 8; mi++) begin
      for (int idx = 0; idx < 15; idx++) begin
        @(negedge clk);
        mode_i = modes[mi]; force_user = 1'b0;
        rd_a_idx = 4'(idx); rd_b_idx = 4'(14 - idx);
        #1;
        check(req, $sformatf("portA mode %b idx %0d", modes[mi], idx),
              rd_a_data, model[row_for(modes[mi], 1'b0, idx)][idx]);
        check("R11", $sformatf("portB mode %b idx %0d", modes[mi], 14 - idx),
              rd_b_data, model[row_for(modes[mi], 1'b0, 14 - idx)][14 - idx]);
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int r = 0; r < 6; r++) begin
      save_model[r] = '0;
      for (int i = 0; i < 15; i++) model[r][i] = '0;
    end
    pc_model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    #1;
    check("R1", "illegal after reset", {31'd0, illegal_mode}, '0);
    check("R1", "pc after reset", pc_o, '0);
    for (int mi = 0; mi < 7; mi++) begin
      @(negedge clk); mode_i = modes[mi]; #1;
      check("R1", "saved status after reset", spsr_rdata, '0);
    end
    sweep_reads("R1");

    // R7: illegal flag per code
    for (int mi = 0; mi < 8; mi++) begin
      @(negedge clk); mode_i = modes[mi]; #1;
      check("R7", $sformatf("illegal flag mode %b", modes[mi]),
            {31'd0, illegal_mode}, {31'd0, (mi == 7)});
    end

    // R2..R5, R7: write every index in every mode, sweep all reads after each
    for (int mi = 0; mi < 8; mi++) begin
      for (int idx = 0; idx < 16; idx++)
        wr(modes[mi], 1'b0, idx, {8'hC0 + 8'(mi), 8'(owner_of(modes[mi])), 8'(idx), 8'h3D});
      sweep_reads(mi == 0 ? "R2" : mi == 1 ? "R3" : mi < 6 ? "R4" : mi == 6 ? "R5" : "R7");
    end

    // R8: force_user in fast interrupt mode reaches user copies
    for (int idx = 0; idx < 15; idx++)
      wr(5'b10001, 1'b1, idx, {8'hF0, 8'(idx), 16'hBEEF});
    for (int idx = 0; idx < 15; idx++) begin
      @(negedge clk); mode_i = 5'b10001; force_user = 1'b1; rd_a_idx = 4'(idx); #1;
      check("R8", $sformatf("forced read idx %0d", idx), rd_a_data, model[0][idx]);
      @(negedge clk); mode_i = 5'b10000; force_user = 1'b0; #1;
      check("R8", $sformatf("user view idx %0d", idx), rd_a_data, model[0][idx]);
      @(negedge clk); mode_i = 5'b10001; #1;
      check("R8", $sformatf("fiq bank kept idx %0d", idx), rd_a_data, model[row_for(5'b10001, 1'b0, idx)][idx]);
    end
    force_user = 1'b0;

    // R6: saved status per mode
    for (int mi = 0; mi < 8; mi++) begin
      @(negedge clk);
      mode_i = modes[mi]; spsr_wdata = {16'h5A00, 8'(mi), 8'h77}; spsr_we = 1'b1;
      @(negedge clk);
      spsr_we = 1'b0;
      if (owner_of(modes[mi]) != 0) save_model[owner_of(modes[mi])] = {16'h5A00, 8'(mi), 8'h77};
    end
    for (int mi = 0; mi < 8; mi++) begin
      @(negedge clk); mode_i = modes[mi]; #1;
      check("R6", $sformatf("saved status mode %b", modes[mi]), spsr_rdata, save_model[owner_of(modes[mi])]);
    end

    // R9: same-cycle write and read of one register
    @(negedge clk);
    mode_i = 5'b10011; rd_a_idx = 4'd13; wr_idx = 4'd13; wr_data = 32'h0DDF00D5; wr_en = 1'b1;
    #1;
    check("R9", "read during write", rd_a_data, model[3][13]);
    @(negedge clk);
    wr_en = 1'b0; model[3][13] = 32'h0DDF00D5;
    #1;
    check("R9", "read after write", rd_a_data, 32'h0DDF00D5);

    // R10: program counter
    @(negedge clk);
    pc_next = 32'h0000_1234; pc_we = 1'b1;
    @(negedge clk);
    pc_we = 1'b0; pc_model = 32'h0000_1234;
    rd_a_idx = 4'd15; rd_b_idx = 4'd15;
    #1;
    check("R10", "pc out", pc_o, pc_model);
    check("R10", "portA idx15", rd_a_data, pc_model);
    check("R10", "portB idx15", rd_b_data, pc_model);
    wr(5'b10000, 1'b0, 15, 32'hDEAD_0015);
    #1;
    check("R10", "pc after idx15 write", pc_o, pc_model);
    sweep_reads("R10");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule